// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

This block is an on-chip word memory with a synchronous-SRAM-style access port. On every enabled rising clock edge it captures an address, a set of chip selects, a read/write direction, four active-low byte-lane write masks and a load/advance control. A load cycle starts a new access at the external address. An advance cycle steps a two-bit burst step and forms the next address inside a four-word group. The data phase of each access trails its address cycle by two enabled edges. Reads and writes can therefore be interleaved back to back with no idle turnaround slot.

The word is 32 bits wide and split into four 8-bit lanes. Read data leaves on `dqOut` together with a drive-enable flag, `dqDrive`. An asynchronous active-low output enable gates that flag. Write data arrives on a separate `dataIn` bus in the data phase. An active-low clock enable freezes every register in the block, so a stalled edge simply stretches the previous cycle.

Top module: `burst_sram`

## Requirements
- R1: After reset, with `oeN` low, `dqDrive` is 0 and `dqOut` is all zeros until a selected read reaches its data phase.
- R2: A selected read loaded at enabled edge E0 drives `dqOut` with the stored word, and raises `dqDrive`, right after enabled edge E2 and not after E1.
- R3: A selected write loaded at edge E0 stores `dataIn` as sampled at enabled edge E2. Only lanes whose `byteWrN` bit is 0 in the address cycle are written, where bit i covers data bits 8i+7..8i.
- R4: With `seqMode` = 0 at load, beat k of a burst (load = beat 0, each advance +1) uses low address bits (start + k) mod 4. The upper address bits are fixed at their loaded value.
- R5: With `seqMode` = 1 at load, beat k uses low address bits start XOR k. `seqMode` is sampled only on load cycles.
- R6: On an advance cycle (`loadN` = 1), `readSel` and all three chip selects are ignored. The burst keeps the direction and selection it had at load, while `byteWrN` is taken fresh for each beat.
- R7: The block is selected only when `selLoN0` = 0, `selLoN1` = 0 and `selHi` = 1 on a load cycle. A deselected load, and any advance that follows it, produces no write and no drive in its data slot.
- R8: While `clkEnN` = 1, clock edges are ignored: `dqOut`, `dqDrive`, the pipeline, the burst step and the memory hold, and `dataIn` is not sampled.
- R9: `oeN` = 1 forces `dqDrive` to 0 and `dqOut` to zero at once, with no clock edge. It leaves the stored read word in place, so lowering `oeN` brings the data back.
- R10: A read loaded one cycle after a write to the same address returns the newly written word, with no idle slot between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEnN | input | 1 | Active-low clock enable; high stalls the whole block |
| loadN | input | 1 | Low loads a new address; high advances the burst |
| readSel | input | 1 | 1 = read, 0 = write; sampled on load cycles only |
| selLoN0 | input | 1 | Active-low chip select |
| selLoN1 | input | 1 | Active-low chip select |
| selHi | input | 1 | Active-high chip select |
| byteWrN | input | 4 | Active-low lane write masks, given with the address |
| seqMode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| addr | input | AW | Word address (AW = log2 DEPTH) |
| dataIn | input | 32 | Write data, sampled in the data phase |
| oeN | input | 1 | Asynchronous active-low output enable |
| dqOut | output | 32 | Read data, zero when not driven |
| dqDrive | output | 1 | Read drivers enabled |

## Verification
Single reads and writes show the two-edge latency and prove that nothing arrives after one edge. Partial lane masks and per-beat masks inside a write burst separate lane-accurate merging from whole-word writes. Linear and interleaved bursts start from non-zero low address bits. During their advances, `seqMode`, `readSel` and the chip selects are deliberately flipped, which exposes any address order that wraps wrongly or any control that is resampled mid-burst. Further patterns cover each of the three deselect combinations, stalls in the middle of both a read and a write, toggling of the output enable, and a write followed at once by a read of the same word.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  // strobes handed from the control to the datapath for the data phase
  typedef struct packed {
    logic             rdStrobe;
    logic             wrStrobe;
    logic [LANES-1:0] laneWr;
  } strobe_t;

  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic interleave);
    return interleave ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEnN,
  input  logic                 loadN,
  input  logic                 readSel,
  input  logic                 selLoN0,
  input  logic                 selLoN1,
  input  logic                 selHi,
  input  logic [LANES-1:0]     byteWrN,
  input  logic                 seqMode,
  input  logic [AW-1:0]        addr,
  output strobe_t              stb,
  output logic [AW-1:0]        memAddr
);
  // burst state captured on load cycles
  logic [AW-3:0] hiPart;
  logic [1:0]    startLo, step;
  logic          bRead, bSel, bMode;

  // slot pipeline: stage A (after address edge), stage B (data phase)
  logic             aValid, aRead, bValid, bReadS;
  logic [AW-1:0]    aAddr, bAddr;
  logic [LANES-1:0] aLaneN, bLaneN;

  logic          selNow;
  logic [1:0]    nextStep, lowNow;
  logic          issueValid, issueRead;
  logic [AW-1:0] issueAddr;

  always_comb begin
    selNow     = !selLoN0 && !selLoN1 && selHi;
    nextStep   = loadN ? step + 2'd1 : 2'd0;
    lowNow     = burstLow(startLo, nextStep, bMode);
    issueValid = loadN ? bSel  : selNow;
    issueRead  = loadN ? bRead : readSel;
    issueAddr  = loadN ? {hiPart, lowNow} : addr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiPart <= '0; startLo <= '0; step <= '0;
      bRead <= 1'b0; bSel <= 1'b0; bMode <= 1'b0;
      aValid <= 1'b0; aRead <= 1'b0; aAddr <= '0; aLaneN <= '1;
      bValid <= 1'b0; bReadS <= 1'b0; bAddr <= '0; bLaneN <= '1;
    end else if (!clkEnN) begin
      if (!loadN) begin
        hiPart  <= addr[AW-1:2];
        startLo <= addr[1:0];
        bRead   <= readSel;
        bSel    <= selNow;
        bMode   <= seqMode;
      end
      step   <= nextStep;
      aValid <= issueValid;
      aRead  <= issueRead;
      aAddr  <= issueAddr;
      aLaneN <= byteWrN;
      bValid <= aValid;
      bReadS <= aRead;
      bAddr  <= aAddr;
      bLaneN <= aLaneN;
    end
  end

  always_comb begin
    stb.rdStrobe = bValid && bReadS;
    stb.wrStrobe = bValid && !bReadS;
    stb.laneWr   = stb.wrStrobe ? ~bLaneN : '0;
    memAddr      = bAddr;
  end
endmodule

// File: rtl/bsram_dpath.sv
module bsram_dpath
  import bsram_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  strobe_t           stb,
  input  logic [AW-1:0]     memAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              oeN,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqDrive
);
  logic [WORD_W-1:0] rdWord;
  logic              outValid;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (!clkEnN) begin
        if (stb.laneWr[g]) laneMem[memAddr] <= dataIn[g*LANE_W +: LANE_W];
        if (stb.rdStrobe)  laneQ <= laneMem[memAddr];
      end
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        outValid <= 1'b0;
    else if (!clkEnN) outValid <= stb.rdStrobe;
  end

  assign dqDrive = outValid && !oeN;
  assign dqOut   = dqDrive ? rdWord : '0;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              loadN,
  input  logic              readSel,
  input  logic              selLoN0,
  input  logic              selLoN1,
  input  logic              selHi,
  input  logic [LANES-1:0]  byteWrN,
  input  logic              seqMode,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              oeN,
  output logic [WORD_W-1:0] dqOut,
  output logic              dqDrive
);
  strobe_t       stb;
  logic [AW-1:0] memAddr;

  bsram_ctrl #(.AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN),
    .readSel(readSel), .selLoN0(selLoN0), .selLoN1(selLoN1), .selHi(selHi),
    .byteWrN(byteWrN), .seqMode(seqMode), .addr(addr),
    .stb(stb), .memAddr(memAddr)
  );

  bsram_dpath #(.DEPTH(DEPTH), .AW(AW)) uDp (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .stb(stb), .memAddr(memAddr),
    .dataIn(dataIn), .oeN(oeN), .dqOut(dqOut), .dqDrive(dqDrive)
  );
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk (
  input logic        clk,
  input logic        rstN,
  input logic        clkEnN,
  input logic        loadN,
  input logic        readSel,
  input logic        selLoN0,
  input logic        selLoN1,
  input logic        selHi,
  input logic        oeN,
  input logic [31:0] dqOut,
  input logic        dqDrive
);
  localparam logic [1:0] SLOT_NONE = 2'd0;
  localparam logic [1:0] SLOT_RD   = 2'd1;
  localparam logic [1:0] SLOT_OFF  = 2'd2;

  // slot kinds seen at the ports, tracked over enabled edges (load cycles only)
  logic [1:0] slot0, slot1, slotNow;

  always_comb begin
    if (loadN)                                    slotNow = SLOT_NONE;
    else if (!selLoN0 && !selLoN1 && selHi)       slotNow = readSel ? SLOT_RD : SLOT_NONE;
    else                                          slotNow = SLOT_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slot0 <= SLOT_NONE;
      slot1 <= SLOT_NONE;
    end else if (!clkEnN) begin
      slot0 <= slotNow;
      slot1 <= slot0;
    end
  end

  // R2: a loaded read drives the bus right after its second enabled edge
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && slot1 == SLOT_RD) |=> (oeN || dqDrive));

  // R7: a deselected load leaves its data slot undriven
  p_deselect_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && slot1 == SLOT_OFF) |=> !dqDrive);

  // R8: a stalled edge changes nothing at the outputs
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clkEnN) && !oeN && $past(!oeN)) |-> ($stable(dqOut) && $stable(dqDrive)));

  // R9: output enable high keeps the drivers off
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dqDrive);

  // R9: an undriven bus carries zeros
  p_bus_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !dqDrive |-> (dqOut == 32'h0));
endmodule

bind burst_sram bsram_chk uChk (
  .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN), .readSel(readSel),
  .selLoN0(selLoN0), .selLoN1(selLoN1), .selHi(selHi), .oeN(oeN),
  .dqOut(dqOut), .dqDrive(dqDrive)
);

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;
  localparam int DEPTH = 256;
  localparam int AW    = 8;

  logic        clk = 1'b0;
  logic        rstN, clkEnN, loadN, readSel, selLoN0, selLoN1, selHi, seqMode, oeN;
  logic [3:0]  byteWrN;
  logic [AW-1:0] addr;
  logic [31:0] dataIn, dqOut;
  logic        dqDrive;

  logic [31:0] refMem [DEPTH];
  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  burst_sram #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .loadN(loadN), .readSel(readSel),
    .selLoN0(selLoN0), .selLoN1(selLoN1), .selHi(selHi), .byteWrN(byteWrN),
    .seqMode(seqMode), .addr(addr), .dataIn(dataIn), .oeN(oeN),
    .dqOut(dqOut), .dqDrive(dqDrive)
  );

  always #5 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] beN);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (!beN[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] pat(input int a);
    return {a[7:0], 8'hC3, 8'(a * 3), 8'h5A};
  endfunction

  task automatic setLoad(input logic rd, input logic [AW-1:0] a, input logic [3:0] beN,
                         input logic mode);
    clkEnN = 0; loadN = 0; readSel = rd; addr = a; byteWrN = beN; seqMode = mode;
    selLoN0 = 0; selLoN1 = 0; selHi = 1;
  endtask

  task automatic setNop();
    clkEnN = 0; loadN = 0; readSel = 1; byteWrN = 4'h0;
    selLoN0 = 0; selLoN1 = 0; selHi = 0;
  endtask

  task automatic setAdv(input logic bogusRd, input logic bogusMode, input logic [3:0] beN);
    clkEnN = 0; loadN = 1; readSel = bogusRd; seqMode = bogusMode; byteWrN = beN;
    selLoN0 = 1; selLoN1 = 1; selHi = 0; addr = 8'hFF;
  endtask

  task automatic writeWord(input logic [AW-1:0] a, input logic [3:0] beN, input logic [31:0] d);
    setLoad(0, a, beN, 0); dataIn = 32'hDEAD0001; tick();
    setNop(); tick();
    dataIn = d; tick();
    dataIn = 32'hDEAD0002;
    refMem[a] = merge(refMem[a], d, beN);
  endtask

  task automatic readCheck(input logic [AW-1:0] a, input string req);
    setLoad(1, a, 4'hF, 0); tick();
    setNop(); tick(); tick();
    chk(req, {31'b0, dqDrive}, 32'h1);
    chk(req, dqOut, refMem[a]);
  endtask

  // R1: idle bus after reset
  task automatic t_reset();
    chk("R1 drive after reset", {31'b0, dqDrive}, 32'h0);
    chk("R1 data after reset", dqOut, 32'h0);
  endtask

  // R10: back-to-back writes filling words 0..31, no gaps
  task automatic t_fill();
    for (int i = 0; i < 34; i++) begin
      if (i < 32) setLoad(0, 8'(i), 4'h0, 0); else setNop();
      dataIn = (i >= 2) ? pat(i - 2) : 32'hBAD0BAD0;
      tick();
      if (i >= 2) refMem[i - 2] = pat(i - 2);
    end
    readCheck(8'd0, "R10 fill word 0");
    readCheck(8'd31, "R10 fill word 31");
  endtask

  // R2: two-edge read latency
  task automatic t_latency();
    setLoad(1, 8'd5, 4'hF, 0); tick();
    setNop(); tick();
    chk("R2 not driven after one edge", {31'b0, dqDrive}, 32'h0);
    tick();
    chk("R2 driven after two edges", {31'b0, dqDrive}, 32'h1);
    chk("R2 read data", dqOut, refMem[5]);
    tick();
  endtask

  // R3: partial lane write
  task automatic t_lanes();
    writeWord(8'd3, 4'b1010, 32'h11223344);
    readCheck(8'd3, "R3 lanes 0 and 2 only");
    writeWord(8'd4, 4'b0111, 32'hAABBCCDD);
    readCheck(8'd4, "R3 lane 3 only");
    writeWord(8'd9, 4'b1111, 32'h0);
    readCheck(8'd9, "R3 no lanes");
  endtask

  // R4/R5/R6: four-beat burst with control noise on advance cycles
  task automatic burst(input logic [AW-1:0] start, input logic il, input logic isRead,
                       input logic [3:0][3:0] beArr, input logic [3:0][31:0] wd,
                       input string req);
    logic [AW-1:0] ba [4];
    for (int k = 0; k < 4; k++)
      ba[k] = {start[AW-1:2], il ? (start[1:0] ^ 2'(k)) : (start[1:0] + 2'(k))};
    for (int j = 0; j < 6; j++) begin
      if (j == 0)     setLoad(isRead, start, beArr[0], il);
      else if (j < 4) setAdv(!isRead, !il, beArr[j]);
      else            setNop();
      dataIn = (!isRead && j >= 2) ? wd[j - 2] : 32'hBADBAD00 + j;
      tick();
      if (isRead && j >= 2) begin
        chk(req, {31'b0, dqDrive}, 32'h1);
        chk(req, dqOut, refMem[ba[j - 2]]);
      end
    end
    if (!isRead)
      for (int k = 0; k < 4; k++) refMem[ba[k]] = merge(refMem[ba[k]], wd[k], beArr[k]);
  endtask

  task automatic t_bursts();
    logic [3:0][31:0] wd;
    wd = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    burst(8'd6, 0, 1, {4'hF, 4'hF, 4'hF, 4'hF}, wd, "R4 linear read from low 2");
    burst(8'd9, 1, 1, {4'hF, 4'hF, 4'hF, 4'hF}, wd, "R5 interleaved read from low 1");
    burst(8'd15, 1, 1, {4'hF, 4'hF, 4'hF, 4'hF}, wd, "R5 interleaved read from low 3");
    burst(8'd14, 0, 0, {4'b1100, 4'b0000, 4'b0011, 4'b0000}, wd,
          "R6 write burst per-beat lanes");
    for (int k = 12; k < 16; k++) readCheck(8'(k), "R6 write burst readback");
    burst(8'd21, 1, 0, {4'h0, 4'h0, 4'h0, 4'h0}, wd, "R5 interleaved write");
    for (int k = 20; k < 24; k++) readCheck(8'(k), "R5 interleaved write readback");
  endtask

  // R7: each deselect combination blocks writes and drive
  task automatic t_deselect();
    logic [2:0] combos [3];
    combos[0] = 3'b101; combos[1] = 3'b011; combos[2] = 3'b000;
    writeWord(8'd50, 4'h0, 32'h50505050);
    for (int c = 0; c < 3; c++) begin
      setLoad(0, 8'd50, 4'h0, 0);
      {selLoN0, selLoN1, selHi} = combos[c];
      dataIn = 32'hBAD1BAD1; tick();
      setAdv(0, 0, 4'h0); tick();
      setNop(); dataIn = 32'hBAD2BAD2; tick(); tick();
      readCheck(8'd50, "R7 deselected write ignored");
      setLoad(1, 8'd50, 4'hF, 0);
      {selLoN0, selLoN1, selHi} = combos[c];
      tick();
      setAdv(1, 0, 4'hF); tick();
      setNop(); tick();
      chk("R7 deselected read undriven", {31'b0, dqDrive}, 32'h0);
      tick();
      chk("R7 advance after deselect undriven", {31'b0, dqDrive}, 32'h0);
    end
  endtask

  // R8: stalls hold read output and skip dataIn sampling
  task automatic t_stall();
    setLoad(1, 8'd5, 4'hF, 0); tick();
    clkEnN = 1; tick(); tick();
    setNop(); tick();
    clkEnN = 1; tick();
    chk("R8 stall delays drive", {31'b0, dqDrive}, 32'h0);
    setNop(); tick();
    chk("R8 read after stalls", dqOut, refMem[5]);
    setLoad(1, 8'd6, 4'hF, 0); clkEnN = 1; tick(); tick();
    chk("R8 output held in stall", dqOut, refMem[5]);
    chk("R8 drive held in stall", {31'b0, dqDrive}, 32'h1);
    setNop(); tick(); tick();
    setLoad(0, 8'd40, 4'h0, 0); tick();
    setNop(); tick();
    clkEnN = 1; dataIn = 32'hBADBADFF; tick();
    setNop(); dataIn = 32'h40404040; tick();
    refMem[40] = 32'h40404040;
    readCheck(8'd40, "R8 write sampled at enabled edge");
  endtask

  // R9: asynchronous output enable
  task automatic t_oe();
    setLoad(1, 8'd7, 4'hF, 0); tick();
    setNop(); tick(); tick();
    oeN = 1; #1;
    chk("R9 oe high drive", {31'b0, dqDrive}, 32'h0);
    chk("R9 oe high data", dqOut, 32'h0);
    oeN = 0; #1;
    chk("R9 oe low restores data", dqOut, refMem[7]);
    oeN = 1; setLoad(1, 8'd8, 4'hF, 0); tick();
    setNop(); tick(); tick();
    oeN = 0; #1;
    chk("R9 read under oe high kept", dqOut, refMem[8]);
  endtask

  // R10: write then immediate read of the same word
  task automatic t_b2b();
    setLoad(0, 8'd60, 4'h0, 0); dataIn = 32'h0; tick();
    setLoad(1, 8'd60, 4'hF, 0); tick();
    setLoad(0, 8'd61, 4'h0, 0); dataIn = 32'h60606060; tick();
    setLoad(1, 8'd61, 4'hF, 0); dataIn = 32'hBADBAD60; tick();
    chk("R10 read after write", dqOut, 32'h60606060);
    setNop(); dataIn = 32'h61616161; tick();
    chk("R10 no turnaround slot", {31'b0, dqDrive}, 32'h0);
    tick();
    chk("R10 second read after write", dqOut, 32'h61616161);
    refMem[60] = 32'h60606060; refMem[61] = 32'h61616161;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) refMem[i] = 32'h0;
    rstN = 0; oeN = 0; dataIn = 0; addr = 0; seqMode = 0;
    setNop();
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    t_reset();
    t_fill();
    t_latency();
    t_lanes();
    t_bursts();
    t_deselect();
    t_stall();
    t_oe();
    t_b2b();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule